// File: doc/BRIEF.md
# Transmit-Opportunity Budget Tracker

This block works out how much transmit-opportunity (TXOP) time a scheduled transmit command may use. Each command arrives in one cycle with its own budget in 4 µs units, a mode bit, a flag saying whether it is the first command after a backoff expiry, and the current distances to the next beacon boundary and to the command's lifetime expiry. One cycle later the block presents the granted TXOP: the smallest of all the limits that apply.

Two budgeting modes exist. In fixed mode the command's own budget is one of the limits and no state is kept. In shared mode one internal down-counting timer serves a whole burst: the first command after a backoff expiry loads it with its budget. The timer then waits for the start of frame transmission and counts down once per 4 µs tick, which a clock prescaler derives. Later commands of the same burst ignore their own budget and inherit whatever remains. For commands sent in software transmit mode the block also reports whether a supplied total transmit time fits inside the grant.

Top module: `txop_budget_tracker`

## Requirements
- R1: After reset, out_valid, granted_txop and txop_fits are all 0, and the shared timer holds 0.
- R2: In fixed mode (cmd_mode = 0), out_valid is high in the cycle after cmd_valid and granted_txop equals the minimum of cmd_budget, beacon_left and (when enabled) life_left; between commands granted_txop holds its value.
- R3: When cmd_life_en = 0 the lifetime distance takes no part in the minimum; when 1 it does.
- R4: A shared-mode command (cmd_mode = 1) with cmd_first = 1 loads the timer with cmd_budget, and its own grant is the minimum of cmd_budget and the other limits. A later load replaces the timer value, even while the timer is counting.
- R5: A loaded timer holds its value until tx_start is sampled high; counting begins on that edge, not on the load.
- R6: While counting, the timer drops by one every PRESCALE clock cycles. The first drop comes PRESCALE edges after the tx_start edge, and the timer saturates at 0.
- R7: A shared-mode command with cmd_first = 0 ignores its cmd_budget and uses the timer value held before its own sampling edge, taking the minimum with the other limits. The grant is 0 if the timer was never loaded since reset.
- R8: Fixed-mode commands and shared-mode commands with cmd_first = 0 leave the timer untouched.
- R9: With cmd_sw_mode = 1, txop_fits is 1 exactly when cmd_total_time <= the granted value. With cmd_sw_mode = 0 it is 0.
- R10: A tx_start pulse while the timer is already counting has no effect on the count schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_mode | input | 1 | 0 fixed budget, 1 shared timer |
| cmd_first | input | 1 | Command is the first after a backoff expiry |
| cmd_budget | input | TIME_W | Command's maximum TXOP, 4 µs units |
| cmd_life_en | input | 1 | Lifetime limit applies to this command |
| cmd_sw_mode | input | 1 | Command uses software transmit mode |
| cmd_total_time | input | TIME_W | Requested total transmit time, 4 µs units |
| beacon_left | input | TIME_W | Time remaining to next beacon boundary |
| life_left | input | TIME_W | Time remaining to command lifetime expiry |
| tx_start | input | 1 | Frame transmission begins (pulse) |
| out_valid | output | 1 | Grant outputs refreshed this cycle |
| granted_txop | output | TIME_W | Granted TXOP, 4 µs units |
| txop_fits | output | 1 | Requested total time fits the grant (software mode) |

## Verification
The assertions take for granted that the limit inputs and the command fields are stable and known in every cycle where cmd_valid is high. They also assume tx_start is a single-cycle pulse; the timer properties only compare its value across consecutive edges. The stimulus drives every input on the falling edge and holds it for a whole cycle. It keeps tx_start to one-cycle pulses and never raises cmd_valid during reset. The fixed-mode sweep covers zero, small and full-scale values for every limit with the lifetime enable both on and off. The shared-mode run tracks the count schedule by counting clock edges from the sampled tx_start.

// File: rtl/txop_pkg.sv
package txop_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_ARMED = 2'd1,
    TMR_RUN   = 2'd2
  } tmr_state_e;

  localparam logic MODE_FIXED  = 1'b0;
  localparam logic MODE_SHARED = 1'b1;

endpackage

// File: rtl/txop_tick_gen.sv
module txop_tick_gen #(
  parameter int PRESCALE = 320
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_count
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign tick = run && !restart && (cnt == LAST);

      // R6: prescaler never passes its terminal count
      p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    end
  endgenerate

endmodule

// File: rtl/txop_shared_timer.sv
module txop_shared_timer
  import txop_pkg::*;
#(
  parameter int TIME_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              start,
  input  logic              tick,
  output logic              running,
  output logic [TIME_W-1:0] value
);

  tmr_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TMR_IDLE;
      value <= '0;
    end else if (load) begin
      value <= load_val;
      state <= start ? TMR_RUN : TMR_ARMED;
    end else begin
      if (start && state == TMR_ARMED) begin
        state <= TMR_RUN;
      end
      if (state == TMR_RUN && tick && value != '0) begin
        value <= value - 1'b1;
      end
    end
  end

  assign running = (state == TMR_RUN);

  // R4: a load takes the command budget
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> value == $past(load_val));

  // R5: an armed timer does not move
  p_hold_armed_r5: assert property (@(posedge clk) disable iff (rst)
    (state == TMR_ARMED && !load) |=> value == $past(value));

  // R6: counting moves by at most one step, downward
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (running && !load) |=> (value == $past(value) || value == $past(value) - 1'b1));

  // R6: saturation at zero
  p_sat_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (running && value == '0 && !load) |=> value == '0);

endmodule

// File: rtl/txop_limit_min.sv
module txop_limit_min #(
  parameter int TIME_W = 14,
  parameter int NUM_LIM = 3
) (
  input  logic [NUM_LIM-1:0][TIME_W-1:0] lim,
  input  logic [NUM_LIM-1:0]             lim_en,
  output logic [TIME_W-1:0]              min_out
);

  always_comb begin
    min_out = '1;
    for (int i = 0; i < NUM_LIM; i++) begin
      if (lim_en[i] && lim[i] < min_out) begin
        min_out = lim[i];
      end
    end
  end

endmodule

// File: rtl/txop_budget_tracker.sv
module txop_budget_tracker
  import txop_pkg::*;
#(
  parameter int TIME_W   = 14,
  parameter int PRESCALE = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_mode,
  input  logic              cmd_first,
  input  logic [TIME_W-1:0] cmd_budget,
  input  logic              cmd_life_en,
  input  logic              cmd_sw_mode,
  input  logic [TIME_W-1:0] cmd_total_time,
  input  logic [TIME_W-1:0] beacon_left,
  input  logic [TIME_W-1:0] life_left,
  input  logic              tx_start,
  output logic              out_valid,
  output logic [TIME_W-1:0] granted_txop,
  output logic              txop_fits
);

  localparam int NUM_LIM = 3;

  logic              load;
  logic              inherit;
  logic              running;
  logic              tick;
  logic [TIME_W-1:0] tmr_val;
  logic [TIME_W-1:0] budget;
  logic [TIME_W-1:0] min_lim;
  logic [NUM_LIM-1:0][TIME_W-1:0] lims;
  logic [NUM_LIM-1:0]             lims_en;

  assign load    = cmd_valid && cmd_mode == MODE_SHARED && cmd_first;
  assign inherit = cmd_mode == MODE_SHARED && !cmd_first;
  assign budget  = inherit ? tmr_val : cmd_budget;

  assign lims    = {life_left, beacon_left, budget};
  assign lims_en = {cmd_life_en, 1'b1, 1'b1};

  txop_tick_gen #(
    .PRESCALE(PRESCALE)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (running),
    .restart(load),
    .tick   (tick)
  );

  txop_shared_timer #(
    .TIME_W(TIME_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(cmd_budget),
    .start   (tx_start),
    .tick    (tick),
    .running (running),
    .value   (tmr_val)
  );

  txop_limit_min #(
    .TIME_W (TIME_W),
    .NUM_LIM(NUM_LIM)
  ) u_min (
    .lim    (lims),
    .lim_en (lims_en),
    .min_out(min_lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      granted_txop <= '0;
      txop_fits    <= 1'b0;
    end else begin
      out_valid <= cmd_valid;
      if (cmd_valid) begin
        granted_txop <= min_lim;
        txop_fits    <= cmd_sw_mode && (cmd_total_time <= min_lim);
      end
    end
  end

  // R2: result is presented exactly one cycle after a command
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> out_valid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !out_valid);

  // R2: grant never exceeds the beacon distance
  p_grant_beacon_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> granted_txop <= $past(beacon_left));

  // R2: fixed-mode grant never exceeds the command budget
  p_grant_budget_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_mode == MODE_FIXED) |=> granted_txop <= $past(cmd_budget));

  // R2: grant holds between commands
  p_grant_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(granted_txop));

  // R3: an enabled lifetime bounds the grant
  p_grant_life_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_life_en) |=> granted_txop <= $past(life_left));

  // R9: fit flag only in software transmit mode
  p_fits_sw_only_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_sw_mode) |=> !txop_fits);

  // R9: a fit never claims more than the grant
  p_fits_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_sw_mode) |=> (!txop_fits || $past(cmd_total_time) <= granted_txop));

endmodule

// File: tb/txop_budget_tracker_tb.sv
module txop_budget_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 14;
  localparam int P  = 4;
  localparam int MAXV = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_mode = 1'b0;
  logic          cmd_first = 1'b0;
  logic [TW-1:0] cmd_budget = '0;
  logic          cmd_life_en = 1'b0;
  logic          cmd_sw_mode = 1'b0;
  logic [TW-1:0] cmd_total_time = '0;
  logic [TW-1:0] beacon_left = '0;
  logic [TW-1:0] life_left = '0;
  logic          tx_start = 1'b0;
  logic          out_valid;
  logic [TW-1:0] granted_txop;
  logic          txop_fits;

  int checks = 0;
  int failures = 0;
  int edge_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  txop_budget_tracker #(.TIME_W(TW), .PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_first(cmd_first), .cmd_budget(cmd_budget), .cmd_life_en(cmd_life_en),
    .cmd_sw_mode(cmd_sw_mode), .cmd_total_time(cmd_total_time),
    .beacon_left(beacon_left), .life_left(life_left), .tx_start(tx_start),
    .out_valid(out_valid), .granted_txop(granted_txop), .txop_fits(txop_fits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c, input bit c_en);
    int m;
    m = (a < b) ? a : b;
    if (c_en && c < m) m = c;
    return m;
  endfunction

  // expected timer value seen by a command sampled at edge c, after load L and start at edge s
  function automatic int tmr_exp(input int l, input int s, input int c);
    int d;
    if (c <= s) return l;
    d = (c - s - 1) / P;
    return (l > d) ? l - d : 0;
  endfunction

  task automatic issue(input bit mode, input bit first, input int bud, input int bcn,
                       input int life, input bit len, input bit sw, input int tot,
                       output int c_edge);
    @(negedge clk);
    cmd_mode = mode; cmd_first = first; cmd_budget = TW'(bud);
    beacon_left = TW'(bcn); life_left = TW'(life); cmd_life_en = len;
    cmd_sw_mode = sw; cmd_total_time = TW'(tot);
    cmd_valid = 1'b1;
    c_edge = edge_cnt + 1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_start(output int s_edge);
    @(negedge clk);
    tx_start = 1'b1;
    s_edge = edge_cnt + 1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int vals[5];
    int c, s, l, e, exp, tot;
    vals[0] = 0; vals[1] = 1; vals[2] = 7; vals[3] = 200; vals[4] = MAXV;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 granted_txop", granted_txop, 0);
    chk("R1 txop_fits", txop_fits, 0);
    // R7 timer never loaded: inherited grant is 0
    issue(1, 0, 500, MAXV, 0, 0, 0, 0, c);
    chk("R7 unloaded inherit", granted_txop, 0);
    chk("R2 out_valid pulse", out_valid, 1);
    @(negedge clk);
    chk("R2 out_valid drop", out_valid, 0);
    chk("R2 grant hold", granted_txop, 0);

    // R2/R3/R9 fixed-mode sweep
    for (int m = 0; m < 5; m++)
      for (int b = 0; b < 5; b++)
        for (int li = 0; li < 5; li++)
          for (int en = 0; en < 2; en++) begin
            exp = min3(vals[m], vals[b], vals[li], en[0]);
            tot = (li % 3 == 0) ? exp : ((li % 3 == 1) ? exp + 1 : exp - 1);
            if (tot < 0) tot = 0;
            if (tot > MAXV) tot = MAXV;
            issue(0, 0, vals[m], vals[b], vals[li], en[0], b[0], tot, c);
            chk(en ? "R2 fixed min" : "R3 lifetime excluded", granted_txop, exp);
            chk("R9 fits", txop_fits, (b[0] && tot <= exp) ? 1 : 0);
          end

    // R4 load with first command
    l = 20;
    issue(1, 1, l, MAXV, 0, 0, 0, 0, c);
    chk("R4 first grant", granted_txop, l);
    issue(1, 1, 30, MAXV, 12, 1, 0, 0, c);
    chk("R4 first grant with lifetime", granted_txop, 12);
    l = 30;
    repeat (10) @(negedge clk);
    // R5 armed timer holds, R7 own budget ignored
    issue(1, 0, 9, MAXV, 0, 0, 0, 0, c);
    chk("R5 armed hold", granted_txop, l);
    // R8 fixed command does not touch timer
    issue(0, 1, 3, MAXV, 0, 0, 0, 0, c);
    chk("R8 fixed grant", granted_txop, 3);
    issue(1, 0, 1, MAXV, 0, 0, 0, 0, c);
    chk("R8 timer untouched", granted_txop, l);

    // R6 counting from tx_start
    pulse_start(s);
    for (int i = 0; i < 70; i++) begin
      if (i % 10 == 5) pulse_start(e);   // R10 extra start while counting
      if (i % 7 == 3) begin
        issue(0, 0, 2, MAXV, 0, 0, 0, 0, c);
        chk("R8 fixed during run", granted_txop, 2);
      end
      if (i % 4 == 2) begin
        issue(1, 0, MAXV, 5, 0, 0, 1, 5, c);
        exp = tmr_exp(l, s, c);
        if (exp > 5) exp = 5;
        chk("R7 inherit with beacon", granted_txop, exp);
        chk("R9 fits shared", txop_fits, (5 <= exp) ? 1 : 0);
      end else begin
        issue(1, 0, MAXV, MAXV, 0, 0, 0, 0, c);
        chk((i % 10 > 5) ? "R10 restart ignored" : "R6 count down", granted_txop, tmr_exp(l, s, c));
      end
    end
    issue(1, 0, MAXV, MAXV, 0, 0, 0, 0, c);
    chk("R6 saturate zero", granted_txop, 0);

    // R4 reload during count, then armed again
    issue(1, 1, 7, MAXV, 0, 0, 0, 0, c);
    chk("R4 reload grant", granted_txop, 7);
    repeat (12) @(negedge clk);
    issue(1, 0, MAXV, MAXV, 0, 0, 0, 0, c);
    chk("R5 reload holds", granted_txop, 7);
    pulse_start(s);
    repeat (9) @(negedge clk);
    issue(1, 0, MAXV, MAXV, 0, 0, 0, 0, c);
    chk("R6 count after reload", granted_txop, tmr_exp(7, s, c));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule